// File: doc/BRIEF.md
# Cache-Aware PCI Write Burst Controller

This block plans the write side of a PCI bus master that moves data from a DMA FIFO into host memory. For each bus tenure it picks the command, Memory Write or Memory Write and Invalidate, and the burst length in 32-bit words. The choice depends on the invalidate enable bit, the cache line size setting, how many words the FIFO holds, how many words are left in the transfer, and whether the current address sits on a cache-line boundary. An invalidate burst always covers a whole number of cache lines, and it is the largest such number that the available data allows.

Software starts a transfer with a byte address and a word count. The block raises its bus request, latches a plan when the grant arrives, and counts data phases (cycles with TRDY# low) while it owns the bus. It ends a tenure when the burst is used up, when the target asserts STOP#, or when the latency timer has expired and the grant has been taken away. An invalidate burst cut short by the latency timer stops only on a line boundary. After a target retry the block releases the bus for one cycle and requests it again.

Top module: `wbc_write_planner`

## Requirements
- R1: After reset the block is idle: `req_n` is high, `bus_own` is low, `cmd` reads 4'b0111 (Memory Write), `burst_words`, `rem_words` and `done` are zero.
- R2: The invalidate command 4'b1111 is planned only when `cfg_inv_en` is high and `cfg_line_words` is 2, 4, 8, 16, 32, 64 or 128. Any other line size, or a cleared enable, gives 4'b0111 on every tenure.
- R3: With invalidates allowed, 4'b1111 is planned only when the word offset of `cur_addr` within the line ((addr/4) mod line) is zero and avail = min(`fifo_words`, `rem_words`) is at least one line. Otherwise the plan is 4'b0111.
- R4: An invalidate burst is the largest multiple of the line size not above avail: (avail / line) × line words.
- R5: A Memory Write burst with invalidates allowed is min(avail, line − offset), so it stops at the next line boundary. With invalidates not allowed it is avail.
- R6: In the request state `req_n` is low only while avail is nonzero. A tenure begins on the clock edge where `gnt_n` is sampled low while requesting, and the plan is computed from the inputs and `cur_addr`/`rem_words` of that cycle.
- R7: Each cycle of a tenure with `trdy_n` low moves one word: `cur_addr` grows by 4 and `rem_words` drops by 1. When `rem_words` reaches zero the block returns to idle with a one-cycle `done` pulse, and `cur_addr` equals start address + 4 × length.
- R8: While `gnt_n` stays low, `lat_expired` has no effect. A tenure without STOP# lasts exactly `burst_words` data phases.
- R9: With `lat_expired` high and `gnt_n` high, an invalidate tenure ends on the first data phase that reaches a line boundary, and a Memory Write tenure ends on its next data phase.
- R10: STOP# low with `trdy_n` high before any word has moved in the tenure is a retry. The next cycle has `req_n` high with address and count unchanged, and in the cycle after that the request is raised again.
- R11: STOP# low after data has moved ends the tenure with the moved words counted. The rest of the transfer continues in a later tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_inv_en | input | 1 | Invalidate command enable |
| cfg_line_words | input | 8 | Cache line size in 32-bit words |
| fifo_words | input | 8 | Words currently held in the DMA FIFO |
| start | input | 1 | Start a transfer (accepted when idle, length nonzero) |
| start_addr | input | 32 | Byte address of the transfer (word aligned) |
| start_words | input | 16 | Transfer length in words |
| gnt_n | input | 1 | Bus grant, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| lat_expired | input | 1 | Latency timer has expired |
| req_n | output | 1 | Bus request, active low |
| bus_own | output | 1 | High while a tenure is in progress |
| cmd | output | 4 | Command of the current or last tenure |
| burst_words | output | 16 | Planned burst length of the current or last tenure |
| cur_addr | output | 32 | Byte address of the next word |
| rem_words | output | 16 | Words still to move |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The assertions assume that the configuration inputs stay constant from the accepted start to the done pulse. They also assume that the start address is word aligned, and that the FIFO does not run dry inside a burst it has already committed to. The stimulus follows these rules. It changes the line size and enable only between transfers and always drives aligned addresses. It treats every TRDY# cycle as a word supplied by the FIFO. Its random FIFO level never falls to zero, except in the directed case that checks the request is held back on an empty FIFO.

// File: rtl/wbc_pkg.sv
// Package: shared command codes and sequencer states for the write burst planner.
package wbc_pkg;

    // PCI command encodings used by the planner.
    typedef enum logic [3:0] {
        CMD_MEM_WR     = 4'b0111,
        CMD_MEM_WR_INV = 4'b1111
    } pci_cmd_e;

    // Tenure sequencer states.
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_XFER = 2'd2,
        S_GAP  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/wbc_line_geom.sv
// Module: wbc_line_geom
// Decodes the cache line size and locates the current address inside a line.
// Assumes: line size given in 32-bit words, CLS_W >= 8, byte address word aligned.
module wbc_line_geom #(
    parameter int ADDR_W = 32,
    parameter int CLS_W  = 8
) (
    input  logic              inv_en,
    input  logic [CLS_W-1:0]  cls,
    input  logic [ADDR_W-1:0] addr,
    output logic              line_ok,
    output logic              aligned,
    output logic              last_in_line,
    output logic [2:0]        shift,
    output logic [CLS_W-1:0]  to_bound
);
    localparam int MAX_SH = 7;
    localparam int OFF_W  = MAX_SH;

    logic             legal;
    logic [OFF_W-1:0] mask;
    logic [OFF_W-1:0] off;

    // Purpose: accept only power-of-two sizes from 2 to 128 words and find log2.
    always_comb begin
        legal = 1'b0;
        shift = 3'd0;
        for (int i = 1; i <= MAX_SH; i++) begin
            if (cls == CLS_W'(1 << i)) begin
                legal = 1'b1;
                shift = 3'(i);
            end
        end
    end

    // Purpose: word offset of the address inside the line and distance to its end.
    always_comb begin
        mask         = (OFF_W'(1) << shift) - OFF_W'(1);
        off          = addr[2 +: OFF_W] & mask;
        line_ok      = inv_en & legal;
        aligned      = line_ok & (off == '0);
        last_in_line = line_ok & (off == mask);
        to_bound     = cls - CLS_W'(off);
    end

endmodule

// File: rtl/wbc_burst_sizer.sv
// Module: wbc_burst_sizer
// Chooses the command and burst length for the next tenure from line geometry,
// FIFO level and remaining length. Purely combinational; clock only for checks.
// Assumes: FIFO_W <= LEN_W.
module wbc_burst_sizer
    import wbc_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int FIFO_W = 8,
    parameter int CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_ok,
    input  logic              aligned,
    input  logic [2:0]        shift,
    input  logic [CLS_W-1:0]  to_bound,
    input  logic [FIFO_W-1:0] fifo_words,
    input  logic [LEN_W-1:0]  rem_words,
    output pci_cmd_e          plan_cmd,
    output logic [LEN_W-1:0]  plan_words
);
    logic [LEN_W-1:0] fifo_ext;
    logic [LEN_W-1:0] avail;
    logic [LEN_W-1:0] lines;
    logic [LEN_W-1:0] whole;
    logic [LEN_W-1:0] bound;
    logic [LEN_W-1:0] mw_len;
    logic             use_inv;

    // Purpose: words that can go out now, limited by FIFO and transfer length.
    always_comb begin
        fifo_ext = LEN_W'(fifo_words);
        avail    = (fifo_ext < rem_words) ? fifo_ext : rem_words;
    end

    // Purpose: round the available words down to whole lines.
    always_comb begin
        lines = avail >> shift;
        whole = lines << shift;
    end

    // Purpose: plain write stops at the next line boundary when lines are in use.
    always_comb begin
        bound  = LEN_W'(to_bound);
        if (line_ok)
            mw_len = (avail < bound) ? avail : bound;
        else
            mw_len = avail;
    end

    // Purpose: final command and length selection.
    always_comb begin
        use_inv    = line_ok & aligned & (lines != '0);
        plan_cmd   = use_inv ? CMD_MEM_WR_INV : CMD_MEM_WR;
        plan_words = use_inv ? whole : mw_len;
    end

    // R4: an invalidate plan fits the data and one more line would not.
    a_r4_largest_multiple: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_cmd == CMD_MEM_WR_INV) |->
            (plan_words <= avail) &&
            (({1'b0, plan_words} + ({{LEN_W{1'b0}}, 1'b1} << shift)) > {1'b0, avail}));

    // R5: a plain write with lines in use never crosses a boundary.
    a_r5_mw_to_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_cmd == CMD_MEM_WR && line_ok) |-> (plan_words <= LEN_W'(to_bound)));

endmodule

// File: rtl/wbc_tenure_seq.sv
// Module: wbc_tenure_seq
// Runs a transfer through request, tenure and release, counts data phases and
// ends each tenure on burst end, target stop or latency cut.
// Assumes: target never gives more data phases than the latched burst.
module wbc_tenure_seq
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_words,
    input  logic              gnt_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic              lat_expired,
    input  pci_cmd_e          plan_cmd,
    input  logic [LEN_W-1:0]  plan_words,
    input  logic              aligned,
    input  logic              last_in_line,
    output logic              req_n,
    output logic              bus_own,
    output pci_cmd_e          cmd,
    output logic [LEN_W-1:0]  burst_words,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  rem_words,
    output logic              done
);
    seq_state_e       st;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  left_q;
    logic              moved_q;
    pci_cmd_e          cmd_q;
    logic [LEN_W-1:0]  burst_q;
    logic              done_q;

    logic             word;
    logic             lat_cut;
    logic             end_burst;
    logic             end_lat;
    logic             end_now;
    logic [LEN_W-1:0] rem_after;

    // Purpose: decide whether this cycle closes the tenure.
    always_comb begin
        word      = (st == S_XFER) && !trdy_n;
        lat_cut   = lat_expired && gnt_n;
        end_burst = word && (left_q == LEN_W'(1));
        end_lat   = lat_cut && word && ((cmd_q == CMD_MEM_WR) || last_in_line);
        end_now   = (st == S_XFER) && (!stop_n || end_burst || end_lat);
        rem_after = word ? (rem_q - LEN_W'(1)) : rem_q;
    end

    // Purpose: sequencer state, address and length counters, latched plan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            left_q  <= '0;
            moved_q <= 1'b0;
            cmd_q   <= CMD_MEM_WR;
            burst_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (start && (start_words != '0)) begin
                        addr_q <= start_addr;
                        rem_q  <= start_words;
                        st     <= S_REQ;
                    end
                end
                S_REQ: begin
                    if (!gnt_n && (plan_words != '0)) begin
                        cmd_q   <= plan_cmd;
                        burst_q <= plan_words;
                        left_q  <= plan_words;
                        moved_q <= 1'b0;
                        st      <= S_XFER;
                    end
                end
                S_XFER: begin
                    if (word) begin
                        addr_q  <= addr_q + ADDR_W'(4);
                        rem_q   <= rem_q - LEN_W'(1);
                        left_q  <= left_q - LEN_W'(1);
                        moved_q <= 1'b1;
                    end
                    if (end_now) begin
                        if (rem_after == '0) begin
                            st     <= S_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st <= S_GAP;
                        end
                    end
                end
                S_GAP: st <= S_REQ;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Purpose: drive the outputs from state and registers.
    always_comb begin
        req_n       = !(((st == S_REQ) && (plan_words != '0)) || (st == S_XFER));
        bus_own     = (st == S_XFER);
        cmd         = cmd_q;
        burst_words = burst_q;
        cur_addr    = addr_q;
        rem_words   = rem_q;
        done        = done_q;
    end

    // R1: no request while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> req_n);

    // R7: the burst counter never runs out inside a tenure.
    a_r7_left_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER) |-> (left_q != '0));

    // R8: with the grant held and no stop, only the burst end can close the tenure.
    a_r8_grant_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && !gnt_n && stop_n && !end_burst) |=> (st == S_XFER));

    // R9: an invalidate tenure closed without stop leaves the address on a line boundary.
    a_r9_inv_ends_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        (end_now && stop_n && cmd_q == CMD_MEM_WR_INV) |=> aligned);

    // R10: a retry releases the bus with nothing consumed.
    a_r10_retry_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XFER && !stop_n && trdy_n && !moved_q) |=>
            (st == S_GAP && $stable(rem_q) && $stable(addr_q)));

    // R10: the release lasts one cycle before requesting again.
    a_r10_gap_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_GAP) |=> (st == S_REQ));

endmodule

// File: rtl/wbc_write_planner.sv
// Module: wbc_write_planner (top)
// Write-side command and burst planner for a PCI master draining a DMA FIFO.
// Assumes: configuration stable during a transfer, word-aligned start address,
// FIFO supplies every word of a burst it was planned against.
module wbc_write_planner
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int FIFO_W = 8,
    parameter int CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_inv_en,
    input  logic [CLS_W-1:0]  cfg_line_words,
    input  logic [FIFO_W-1:0] fifo_words,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_words,
    input  logic              gnt_n,
    input  logic              trdy_n,
    input  logic              stop_n,
    input  logic              lat_expired,
    output logic              req_n,
    output logic              bus_own,
    output logic [3:0]        cmd,
    output logic [LEN_W-1:0]  burst_words,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  rem_words,
    output logic              done
);
    logic             line_ok;
    logic             aligned;
    logic             last_in_line;
    logic [2:0]       shift;
    logic [CLS_W-1:0] to_bound;
    pci_cmd_e         plan_cmd;
    logic [LEN_W-1:0] plan_words;
    pci_cmd_e         cmd_e;

    wbc_line_geom #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) u_geom (
        .inv_en       (cfg_inv_en),
        .cls          (cfg_line_words),
        .addr         (cur_addr),
        .line_ok      (line_ok),
        .aligned      (aligned),
        .last_in_line (last_in_line),
        .shift        (shift),
        .to_bound     (to_bound)
    );

    wbc_burst_sizer #(.LEN_W(LEN_W), .FIFO_W(FIFO_W), .CLS_W(CLS_W)) u_sizer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_ok    (line_ok),
        .aligned    (aligned),
        .shift      (shift),
        .to_bound   (to_bound),
        .fifo_words (fifo_words),
        .rem_words  (rem_words),
        .plan_cmd   (plan_cmd),
        .plan_words (plan_words)
    );

    wbc_tenure_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_addr   (start_addr),
        .start_words  (start_words),
        .gnt_n        (gnt_n),
        .trdy_n       (trdy_n),
        .stop_n       (stop_n),
        .lat_expired  (lat_expired),
        .plan_cmd     (plan_cmd),
        .plan_words   (plan_words),
        .aligned      (aligned),
        .last_in_line (last_in_line),
        .req_n        (req_n),
        .bus_own      (bus_own),
        .cmd          (cmd_e),
        .burst_words  (burst_words),
        .cur_addr     (cur_addr),
        .rem_words    (rem_words),
        .done         (done)
    );

    // Purpose: present the command code as a plain vector.
    always_comb cmd = cmd_e;

    // R2: an invalidate tenure needs the enable and a legal power-of-two line size.
    a_r2_inv_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own && cmd == 4'b1111) |->
            (cfg_inv_en && !cfg_line_words[0] && $countones(cfg_line_words) == 1));

    // R4: a fresh invalidate burst is a nonzero whole number of lines.
    a_r4_whole_lines: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_own) && cmd == 4'b1111) |->
            (burst_words != '0) &&
            ((burst_words & LEN_W'(cfg_line_words - CLS_W'(1))) == '0));

endmodule

// File: tb/sim_wbc_write_planner.sv
// Bench: random and directed transfers against a bench-side plan function.
module sim_wbc_write_planner;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_inv_en;
    logic [7:0]  cfg_line_words;
    logic [7:0]  fifo_words;
    logic        start;
    logic [31:0] start_addr;
    logic [15:0] start_words;
    logic        gnt_n, trdy_n, stop_n, lat_expired;
    logic        req_n, bus_own, done;
    logic [3:0]  cmd;
    logic [15:0] burst_words, rem_words;
    logic [31:0] cur_addr;

    wbc_write_planner u0 (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0, cycles = 0;
    int k_trdy = 75, k_stop = 5, k_lat = 25, k_gnt = 70, k_keep = 70, k_fmin = 1, k_fmax = 40;
    int p_en, p_cls, p_fifo, p_addr, p_rem, p_own, p_trdy, p_stop, p_lat, p_gnt;
    int t_words, t_burst, t_cmd, t_rem0, x_addr0, x_len;
    bit retry_chk = 0, saw_done = 0, start_req = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic void plan(input int en, input int cls, input int fifo, input int addr,
                                 input int rem, output int ecmd, output int ew);
        int avail, off;
        bit legal;
        legal = (cls == 2 || cls == 4 || cls == 8 || cls == 16 || cls == 32 || cls == 64 || cls == 128);
        avail = (fifo < rem) ? fifo : rem;
        if (en != 0 && legal) begin
            off = (addr / 4) % cls;
            if (off == 0 && avail >= cls) begin
                ecmd = 15; ew = (avail / cls) * cls;
            end else begin
                ecmd = 7; ew = (avail < cls - off) ? avail : cls - off;
            end
        end else begin
            ecmd = 7; ew = avail;
        end
    endfunction

    function automatic int pct(input int p);
        return ($urandom % 100) < p ? 1 : 0;
    endfunction

    // One cycle: check outputs at the falling edge, then drive the next inputs.
    task automatic step();
        int ecmd, ew, own, w;
        @(negedge clk);
        own = int'(bus_own);
        if (retry_chk) begin
            chk(req_n == 1'b0, "R10 re-request", int'(req_n), 0);
            retry_chk = 0;
        end
        if (own == 1 && p_own == 0) begin
            plan(p_en, p_cls, p_fifo, p_addr, p_rem, ecmd, ew);
            chk(int'(cmd) == ecmd, (ecmd == 15) ? "R3 cmd" : "R2/R5 cmd", int'(cmd), ecmd);
            chk(int'(burst_words) == ew, (ecmd == 15) ? "R4 burst" : "R5 burst", int'(burst_words), ew);
            t_words = 0; t_burst = int'(burst_words); t_cmd = int'(cmd); t_rem0 = int'(rem_words);
        end
        if (p_own == 1) begin
            w = (p_trdy == 0) ? 1 : 0;
            chk(int'(cur_addr) == p_addr + 4 * w, "R7 addr step", int'(cur_addr), p_addr + 4 * w);
            chk(int'(rem_words) == p_rem - w, "R7 count step", int'(rem_words), p_rem - w);
            t_words += w;
            if (own == 0) begin
                if (p_stop == 0) begin
                    if (t_words == 0) begin
                        chk(int'(rem_words) == t_rem0, "R10 no loss", int'(rem_words), t_rem0);
                        chk(req_n == 1'b1, "R10 release", int'(req_n), 1);
                        retry_chk = 1;
                    end else begin
                        chk(t_words <= t_burst, "R11 disconnect", t_words, t_burst);
                        if (!done) chk(req_n == 1'b1, "R11 release", int'(req_n), 1);
                    end
                end else if (p_lat == 1 && p_gnt == 1) begin
                    if (t_cmd == 15)
                        chk((int'(cur_addr) / 4) % p_cls == 0, "R9 line end", (int'(cur_addr) / 4) % p_cls, 0);
                    else
                        chk(p_trdy == 0, "R9 mw cut", p_trdy, 0);
                end else begin
                    chk(t_words == t_burst, "R8 full burst", t_words, t_burst);
                end
                if (done) begin
                    saw_done = 1;
                    chk(int'(cur_addr) == x_addr0 + 4 * x_len, "R7 final addr", int'(cur_addr), x_addr0 + 4 * x_len);
                    chk(rem_words == 16'd0, "R7 final count", int'(rem_words), 0);
                end
            end
        end
        // drive next inputs
        start = start_req; start_req = 0;
        trdy_n = !pct(k_trdy);
        stop_n = !(own == 1 && pct(k_stop) == 1);
        lat_expired = pct(k_lat);
        gnt_n = own == 1 ? !pct(k_keep) : !pct(k_gnt);
        fifo_words = 8'($urandom_range(k_fmax, k_fmin));
        p_en = int'(cfg_inv_en); p_cls = int'(cfg_line_words); p_fifo = int'(fifo_words);
        p_addr = int'(cur_addr); p_rem = int'(rem_words); p_own = own;
        p_trdy = int'(trdy_n); p_stop = int'(stop_n); p_lat = int'(lat_expired); p_gnt = int'(gnt_n);
    endtask

    task automatic begin_xfer(input int en, input int cls, input int addr, input int len);
        cfg_inv_en = en[0]; cfg_line_words = 8'(cls);
        start_addr = 32'(addr); start_words = 16'(len);
        x_addr0 = addr; x_len = len; saw_done = 0; start_req = 1;
        step();
    endtask

    task automatic finish_xfer(input string tag);
        int n;
        n = 0;
        while (!saw_done && n < 5000) begin step(); n++; end
        chk(saw_done, tag, int'(saw_done), 1);
        step();
    endtask

    task automatic knobs_default();
        k_trdy = 75; k_stop = 5; k_lat = 25; k_gnt = 70; k_keep = 70; k_fmin = 1; k_fmax = 40;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int dummy, cls, addr, len, en;
        int legal_set[7] = '{2, 4, 8, 16, 32, 64, 128};
        int bad_set[5] = '{0, 3, 12, 6, 255};
        dummy = $urandom(32'h5eed);
        rst_n = 1'b0; cfg_inv_en = 1'b0; cfg_line_words = 8'd8; fifo_words = 8'd0;
        start = 1'b0; start_addr = '0; start_words = '0;
        gnt_n = 1'b1; trdy_n = 1'b1; stop_n = 1'b1; lat_expired = 1'b0;
        p_own = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_n == 1'b1, "R1 req_n", int'(req_n), 1);
        chk(bus_own == 1'b0, "R1 bus_own", int'(bus_own), 0);
        chk(cmd == 4'b0111, "R1 cmd", int'(cmd), 7);
        chk(burst_words == 16'd0, "R1 burst", int'(burst_words), 0);
        chk(rem_words == 16'd0 && done == 1'b0, "R1 count/done", int'(rem_words), 0);

        // R6: empty FIFO holds the request back
        k_fmin = 0; k_fmax = 0; k_gnt = 0;
        begin_xfer(1, 8, 32'h100, 8);
        repeat (3) begin
            step();
            chk(req_n == 1'b1, "R6 empty fifo", int'(req_n), 1);
        end
        k_fmin = 16; k_fmax = 16;
        step();
        #1 chk(req_n == 1'b0, "R6 request", int'(req_n), 0);
        k_gnt = 100; k_trdy = 100; k_stop = 0; k_lat = 0; k_keep = 100;
        finish_xfer("R6 completes");

        // R8: latency expiry ignored while granted, multi-line invalidate
        k_fmin = 32; k_fmax = 32; k_lat = 100; k_keep = 100;
        begin_xfer(1, 4, 32'h200, 16);
        finish_xfer("R8 completes");

        // R9: latency expiry with grant removed, invalidate and plain write
        k_keep = 0;
        begin_xfer(1, 4, 32'h400, 16);
        finish_xfer("R9 inv completes");
        begin_xfer(0, 4, 32'h600, 6);
        finish_xfer("R9 mw completes");

        // R10: target retries a few times before accepting
        knobs_default();
        k_stop = 100; k_trdy = 0; k_gnt = 100;
        begin_xfer(1, 8, 32'h800, 24);
        repeat (12) step();
        knobs_default();
        finish_xfer("R10 completes");

        // R2/R3/R4/R5/R11 random transfers
        for (int n = 0; n < 80; n++) begin
            knobs_default();
            en = pct(80);
            cls = pct(85) ? legal_set[$urandom % 7] : bad_set[$urandom % 5];
            addr = int'($urandom_range(32'hFFFF, 0)) * 4;
            if (pct(50) && cls > 1) addr = addr - (addr % (cls * 4));
            len = int'($urandom_range(120, 1));
            begin_xfer(en, cls, addr, len);
            finish_xfer("R7 random completes");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule